// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

A target device can keep SDA low if the controller resets partway through a read, because the target is still waiting to shift out the rest of a byte. This block runs once after reset, before the normal I2C controller takes the pins. It works on SCL as an open-drain line: `scl_oe` high pulls SCL low, and `scl_oe` low lets it float high. It watches a two-flop synchronized copy of SDA. While SDA stays low, it applies full SCL clock pulses. It stops when SDA comes free or when a programmed number of pulses has been used up.

A `start` pulse captures two settings: the half-period in system clocks and the pulse limit. The sequence first leaves SCL released for one half-period, then samples SDA.

- If SDA reads high, the block finishes at once.
- If SDA reads low, it holds SCL low for one half-period, releases it for one half-period, and samples again.

On a healthy bus the whole run costs one half-period plus the check cycle. Exactly one of three outcome flags is raised:

- bus was never stuck,
- bus freed after pulsing,
- still stuck after the limit.

`done` is the release indication: once it is high the block no longer drives SCL, and the I2C controller may take over the pins.

Top module: `i2c_bus_unstick`

## Requirements
- R1: SDA passes through two flops before use, so a check acts on the level `sda_in` had two clock edges earlier. Both flops reset to the released (high) level.
- R2: A start taken in idle leaves SCL released for H cycles, then checks SDA in the following cycle. H is `half_div`, or CLK_HZ/(2*100 kHz) = 250 cycles at the defaults when `half_div` is 0. From the start edge to `done`, the run takes H+1+P*(2H+1) cycles, where P is the number of SCL pulses.
- R3: If SDA reads high at the first check, the run ends with `not_hung`=1 and no SCL pulse.
- R4: When a check reads SDA low and the limit is not reached, `scl_oe` is 1 for exactly H cycles and then 0 for H cycles, followed by another check.
- R5: If SDA reads high at a check after one or more pulses, the run ends with `recovered`=1. This holds even when the pulse count equals the limit.
- R6: If SDA reads low at a check after the number of pulses given by the limit, the run ends with `still_hung`=1, having applied exactly that many pulses.
- R7: A limit of 0 with SDA low ends the run with `still_hung`=1 at the first check, with no pulse.
- R8: `done` goes high with exactly one outcome flag, and `done` and the flags hold until the next accepted start, which clears them.
- R9: A start while `busy`=1 has no effect on the running sequence.
- R10: In reset and whenever idle, `scl_oe`=0. Reset clears `busy`, `done` and all flags.
- R11: `half_div` and `max_cycles` are captured at start. Changing them during a run does not alter its timing or limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| half_div | input | DIV_W | SCL half-period in clocks; 0 selects the 100 kHz fallback |
| max_cycles | input | CNT_W | Largest number of SCL pulses to apply |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Run finished; pins handed back |
| not_hung | output | 1 | SDA was high at the first check |
| recovered | output | 1 | SDA came free after pulsing |
| still_hung | output | 1 | SDA still low after the pulse limit |

## Verification
The hardest case to reach is a target that frees SDA on exactly the last allowed pulse, which must still be reported as recovered and not still hung. A target model in the bench counts falling SCL edges and releases SDA after a chosen count. Runs with the count equal to the limit, below it and above it then approach that boundary from both sides. A second hard case is a start, together with new settings, arriving in the middle of a pulse train. The bench injects both at a fixed cycle inside a long run and checks that the timing is unchanged.

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int FALLBACK_HZ = 100_000,
  parameter int DIV_W       = 16,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_div,
  input  logic [CNT_W-1:0] max_cycles,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             busy,
  output logic             done,
  output logic             not_hung,
  output logic             recovered,
  output logic             still_hung
);

  localparam int FB_INT = CLK_HZ / (2 * FALLBACK_HZ);
  localparam logic [DIV_W-1:0] FB_HALF = DIV_W'(FB_INT);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_CHECK, S_LOW, S_HIGH} state_t;

  state_t           state;
  logic             sda_m, sda_q;
  logic [DIV_W-1:0] timer, half_q, half_sel;
  logic [CNT_W-1:0] limit_q, pulses;
  logic             hung;

  assign half_sel = (half_div == '0) ? FB_HALF : half_div;
  assign scl_oe   = (state == S_LOW);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_m <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      sda_m <= sda_in;
      sda_q <= sda_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      timer      <= '0;
      half_q     <= '0;
      limit_q    <= '0;
      pulses     <= '0;
      hung       <= 1'b0;
      done       <= 1'b0;
      not_hung   <= 1'b0;
      recovered  <= 1'b0;
      still_hung <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          half_q     <= half_sel;
          timer      <= half_sel - 1'b1;
          limit_q    <= max_cycles;
          pulses     <= '0;
          hung       <= 1'b0;
          done       <= 1'b0;
          not_hung   <= 1'b0;
          recovered  <= 1'b0;
          still_hung <= 1'b0;
          state      <= S_SETTLE;
        end
        S_SETTLE, S_HIGH: begin
          if (timer == '0) state <= S_CHECK;
          else             timer <= timer - 1'b1;
        end
        S_LOW: begin
          if (timer == '0) begin
            timer <= half_q - 1'b1;
            state <= S_HIGH;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_CHECK: begin
          if (sda_q) begin
            done      <= 1'b1;
            not_hung  <= ~hung;
            recovered <= hung;
            state     <= S_IDLE;
          end else if (pulses == limit_q) begin
            done       <= 1'b1;
            still_hung <= 1'b1;
            state      <= S_IDLE;
          end else begin
            hung   <= 1'b1;
            pulses <= pulses + 1'b1;
            timer  <= half_q - 1'b1;
            state  <= S_LOW;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SCL_LOW_ONLY_HUNG: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> hung); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_oe); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({not_hung, recovered, still_hung}) == 1); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable({done, not_hung, recovered, still_hung})); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable({half_q, limit_q})); // R9
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pulses <= limit_q); // R6
  AST_CLEAN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    not_hung |-> pulses == '0); // R3

endmodule

// File: tb/i2c_bus_unstick_tb.sv
module i2c_bus_unstick_tb;
  localparam int FB = 50_000_000 / (2 * 100_000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] half_div = '0;
  logic [7:0]  max_cycles = '0;
  logic        sda_in = 1'b1;
  logic        scl_oe, busy, done, not_hung, recovered, still_hung;

  int vectors = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  i2c_bus_unstick u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .max_cycles(max_cycles), .sda_in(sda_in), .scl_oe(scl_oe), .busy(busy),
    .done(done), .not_hung(not_hung), .recovered(recovered), .still_hung(still_hung)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit s1 = 1'b1, s2 = 1'b1;
  bit exp_scl = 0, exp_busy = 0, exp_done = 0, exp_nh = 0, exp_rec = 0, exp_sh = 0;

  task automatic tick(output bit seen);
    @(posedge clk);
    seen = s2;
    if (!rst_n) begin s1 = 1'b1; s2 = 1'b1; end
    else begin s2 = s1; s1 = sda_in; end
  endtask

  initial begin : ref_model
    bit seen;
    int h, lim, n;
    bit hung;
    forever begin
      tick(seen);
      if (rst_n && start) begin
        h = (half_div == 0) ? FB : int'(half_div);
        lim = int'(max_cycles);
        exp_busy = 1; exp_done = 0; exp_nh = 0; exp_rec = 0; exp_sh = 0;
        for (int i = 0; i < h; i++) tick(seen);
        n = 0; hung = 0;
        forever begin
          tick(seen);
          if (seen) begin
            exp_done = 1; exp_nh = !hung; exp_rec = hung; exp_busy = 0;
            break;
          end
          if (n == lim) begin
            exp_done = 1; exp_sh = 1; exp_busy = 0;
            break;
          end
          hung = 1; n++; exp_scl = 1;
          for (int i = 0; i < h; i++) tick(seen);
          exp_scl = 0;
          for (int i = 0; i < h; i++) tick(seen);
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && cmp_on) begin
    check("R4 scl_oe", scl_oe, exp_scl);
    check("R1 R9 busy", busy, exp_busy);
    check("R8 done", done, exp_done);
    check("R3 not_hung", not_hung, exp_nh);
    check("R5 recovered", recovered, exp_rec);
    check("R6 still_hung", still_hung, exp_sh);
  end

  // target device: frees SDA after tgt_need falling SCL edges
  int  tgt_need = 0, tgt_cnt = 0;
  bit  tgt_arm = 0, scl_prev = 0;
  always @(negedge clk) begin
    if (tgt_arm) tgt_cnt = 0;
    else if (scl_oe && !scl_prev) tgt_cnt++;
    scl_prev = scl_oe;
    sda_in = (tgt_cnt >= tgt_need);
  end

  task automatic run(int half, int lim, int need, bit disturb, string tag);
    int h, p, cyc, exp_flags;
    h = (half == 0) ? FB : half;
    @(negedge clk); #1;
    half_div = 16'(half); max_cycles = 8'(lim); tgt_need = need; tgt_arm = 1;
    @(negedge clk); #1;
    tgt_arm = 0;
    repeat (4) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 10) begin start = 1; half_div = 16'd1; max_cycles = 8'd0; end
      if (disturb && cyc == 11) start = 0;
    end
    p = (need == 0) ? 0 : ((need <= lim) ? need : lim);
    exp_flags = (need == 0) ? 4 : ((need <= lim) ? 2 : 1);
    check({tag, " R2 latency"}, cyc, h + 1 + p * (2 * h + 1));
    check({tag, " R6 pulse count"}, tgt_cnt, p);
    repeat (3) @(negedge clk);
    check({tag, " R8 outcome held"}, {done, not_hung, recovered, still_hung}, 8 | exp_flags);
    check({tag, " R10 scl released"}, scl_oe, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R10 reset scl_oe", scl_oe, 0);
    check("R10 reset busy", busy, 0);
    check("R10 reset flags", {done, not_hung, recovered, still_hung}, 0);
    @(negedge clk); rst_n = 1;
    cmp_on = 1;
    repeat (2) @(negedge clk);
    run(4, 15, 0, 0, "R3 healthy");
    run(3, 15, 3, 0, "R5 three pulses");
    run(2, 5, 1000, 0, "R6 never frees");
    run(5, 0, 1000, 0, "R7 zero limit");
    run(1, 15, 9, 0, "R5 nine");
    run(2, 12, 12, 0, "R5 need equals limit");
    run(2, 11, 12, 0, "R6 need over limit");
    run(6, 15, 4, 1, "R9 R11 mid-run start");
    run(0, 15, 0, 0, "R2 fallback healthy");
    run(0, 15, 1, 0, "R2 fallback one pulse");
    run(1, 15, 1, 0, "R1 minimal half");
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule